// File: doc/BRIEF.md
# Interlaced Field Decimator with Vertical Line Window

This block watches the timing of an interlaced video stream: a field identity bit, a per-line strobe and a per-sample strobe. It decides which fields go on to a downstream compressor and which lines inside each passed field count as active. It produces a qualifier for each sample, a one-cycle strobe that marks the start of every passed field, and the parity of the field that began most recently.

Three settings are written through a small register port. The first and last active line numbers (10 bits each) set the vertical window. The control word holds a field rate reduction count N, which passes one field and then drops N, and a polarity bit that inverts the parity reported for the field identity input.

Every write lands in a shadow copy. The shadow copies move to the working set only when a field begins, so the window never shifts partway through a field. Software therefore writes new limits once per field. Rewriting the control word restarts the drop pattern, so the next field is passed.

Top module: `vfield_gate`

## Requirements
- R1: After reset all three outputs are low and no sample is qualified before the first field start. The reset window is first line 1, last line 0x3FF, so once a field is passed, every counted line of that field is active.
- R2: Any change of `fld_in` relative to its previous cycle is a field start. If that field is passed, `fld_start_o` is high for exactly the one cycle after the cycle in which the change is seen. It stays low for dropped fields.
- R3: On each field start, `fld_odd_o` takes the value `fld_in` XOR the polarity bit (control bit 8) and holds it until the next field start.
- R4: The line number is 0 at a field start and rises by one on each `line_stb`; a `line_stb` in the field-start cycle itself gives line 1. Samples on line 0 are never qualified, whatever the first-line value is.
- R5: A line is inside the window when first <= line <= last, with both limits inclusive. When last < first, no line of the field is active.
- R6: `pix_act_o` is high in the cycle after a `pix_stb` exactly when the current field is passed and the current line is inside the window. Without `pix_stb` it is low.
- R7: Writes change only the shadow copies. The window and the control word in use change at the first field start after the write cycle, and the working window is unchanged in every other cycle.
- R8: With reduction count N (control bits 4:0, 0 to 31), the fields after the setting takes effect are passed in the pattern one passed, N dropped, starting with a passed field. N=0 passes every field; N=31 passes one field in 32.
- R9: A write to the control word restarts the drop pattern: the next field start passes its field.
- R10: Register map: address 0 holds the first active line in bits 9:0, address 1 holds the last active line in bits 9:0, and address 2 holds the control word. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fld_in | input | 1 | Field identity from the video timing |
| line_stb | input | 1 | One-cycle pulse at each new line |
| pix_stb | input | 1 | One-cycle pulse for each incoming sample |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| pix_act_o | output | 1 | Sample qualifier, one cycle after `pix_stb` |
| fld_start_o | output | 1 | Start-of-passed-field strobe |
| fld_odd_o | output | 1 | Polarity-corrected parity of the current field |

## Verification
A drop counter that strays from its pattern shows up at the next field start: `fld_start_o` either appears for a field that should be dropped or fails to appear for one that should pass. A faulty line counter or working window first shows up at the sample just after the affected line strobe, where `pix_act_o` flips at the wrong line. A shadow copy that reaches the working set early is caught inside the same field, because a sample on a line between the old and new limits changes its qualification one cycle after its strobe.

// File: rtl/vfield_gate_pkg.sv
package vfield_gate_pkg;
  typedef enum logic [1:0] {
    SEL_FIRST = 2'd0,
    SEL_LAST  = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int CTRL_POL_BIT = 8;
endpackage

// File: rtl/vfield_gate_regs.sv
module vfield_gate_regs
  import vfield_gate_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int RED_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fs_i,
  output logic [LINE_W-1:0] first_act_o,
  output logic [LINE_W-1:0] last_act_o,
  output logic [RED_W-1:0]  red_sh_o,
  output logic              pol_sh_o,
  output logic              restart_o
);
  logic [LINE_W-1:0] first_sh, last_sh;
  reg_sel_e sel;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      first_sh    <= LINE_W'(1);
      last_sh     <= '1;
      red_sh_o    <= '0;
      pol_sh_o    <= 1'b0;
      restart_o   <= 1'b0;
      first_act_o <= LINE_W'(1);
      last_act_o  <= '1;
    end else begin
      if (fs_i) begin
        first_act_o <= first_sh;
        last_act_o  <= last_sh;
        restart_o   <= 1'b0;
      end
      if (we_i) begin
        case (sel)
          SEL_FIRST: first_sh <= wdata_i[LINE_W-1:0];
          SEL_LAST:  last_sh  <= wdata_i[LINE_W-1:0];
          SEL_CTRL: begin
            red_sh_o  <= wdata_i[RED_W-1:0];
            pol_sh_o  <= wdata_i[CTRL_POL_BIT];
            restart_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R7
  win_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fs_i |=> ($stable(first_act_o) && $stable(last_act_o)));
endmodule

// File: rtl/vfield_gate_field.sv
module vfield_gate_field #(
  parameter int RED_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fld_i,
  input  logic             pol_i,
  input  logic [RED_W-1:0] red_i,
  input  logic             restart_i,
  output logic             fs_o,
  output logic             keep_o,
  output logic             start_o,
  output logic             odd_o
);
  logic             fld_q;
  logic [RED_W-1:0] cnt, base;

  assign fs_o = fld_i ^ fld_q;
  assign base = restart_i ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q   <= 1'b0;
      cnt     <= '0;
      keep_o  <= 1'b0;
      start_o <= 1'b0;
      odd_o   <= 1'b0;
    end else begin
      fld_q   <= fld_i;
      start_o <= 1'b0;
      if (fs_o) begin
        keep_o  <= (base == '0);
        start_o <= (base == '0);
        odd_o   <= fld_i ^ pol_i;
        cnt     <= (base == red_i) ? '0 : base + RED_W'(1);
      end
    end
  end

  // R8
  drop_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    !restart_i |-> (cnt <= red_i));

  // R2
  start_src_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> ($past(fs_o) && keep_o));
endmodule

// File: rtl/vfield_gate_lines.sv
module vfield_gate_lines #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fs_i,
  input  logic              line_i,
  input  logic              pix_i,
  input  logic              keep_i,
  input  logic [LINE_W-1:0] first_i,
  input  logic [LINE_W-1:0] last_i,
  output logic              act_o
);
  logic [LINE_W-1:0] line_cnt;
  logic              in_win;

  assign in_win = (line_cnt != '0) && (line_cnt >= first_i) && (line_cnt <= last_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_cnt <= '0;
      act_o    <= 1'b0;
    end else begin
      if (fs_i)
        line_cnt <= line_i ? LINE_W'(1) : '0;
      else if (line_i && (line_cnt != '1))
        line_cnt <= line_cnt + LINE_W'(1);
      act_o <= pix_i && keep_i && in_win;
    end
  end

  // R4
  no_line0_chk: assert property (@(posedge clk) disable iff (rst)
    act_o |-> ($past(line_cnt) != '0));

  // R6
  needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    act_o |-> $past(pix_i && keep_i));

  // R5
  win_bound_chk: assert property (@(posedge clk) disable iff (rst)
    act_o |-> $past(first_i <= last_i));
endmodule

// File: rtl/vfield_gate.sv
module vfield_gate #(
  parameter int LINE_W = 10,
  parameter int RED_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fld_in,
  input  logic              line_stb,
  input  logic              pix_stb,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              pix_act_o,
  output logic              fld_start_o,
  output logic              fld_odd_o
);
  logic              fs, keep, pol_sh, restart;
  logic [RED_W-1:0]  red_sh;
  logic [LINE_W-1:0] first_act, last_act;

  vfield_gate_regs #(.LINE_W(LINE_W), .RED_W(RED_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we_i(cfg_we), .addr_i(cfg_addr), .wdata_i(cfg_wdata),
    .fs_i(fs), .first_act_o(first_act), .last_act_o(last_act),
    .red_sh_o(red_sh), .pol_sh_o(pol_sh), .restart_o(restart)
  );

  vfield_gate_field #(.RED_W(RED_W)) u_field (
    .clk(clk), .rst(rst), .fld_i(fld_in), .pol_i(pol_sh), .red_i(red_sh),
    .restart_i(restart), .fs_o(fs), .keep_o(keep), .start_o(fld_start_o),
    .odd_o(fld_odd_o)
  );

  vfield_gate_lines #(.LINE_W(LINE_W)) u_lines (
    .clk(clk), .rst(rst), .fs_i(fs), .line_i(line_stb), .pix_i(pix_stb),
    .keep_i(keep), .first_i(first_act), .last_i(last_act), .act_o(pix_act_o)
  );
endmodule

// File: tb/vfield_gate_test.sv
`timescale 1ns/1ps
module vfield_gate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fld_in = 1'b0, line_stb = 1'b0, pix_stb = 1'b0, cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        pix_act_o, fld_start_o, fld_odd_o;

  int checks = 0, errors = 0;
  logic raw = 1'b0;
  logic pol = 1'b0;

  always #2.5 clk = ~clk;

  vfield_gate uut (
    .clk(clk), .rst(rst), .fld_in(fld_in), .line_stb(line_stb), .pix_stb(pix_stb),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pix_act_o(pix_act_o), .fld_start_o(fld_start_o), .fld_odd_o(fld_odd_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic new_field(bit exp_keep);
    raw = ~raw;
    fld_in = raw;
    @(negedge clk);
    chk("R2 start strobe", fld_start_o, exp_keep);
    chk("R3 parity", fld_odd_o, raw ^ pol);
    @(negedge clk);
    chk("R2 strobe width", fld_start_o, 0);
  endtask

  task automatic line();
    line_stb = 1'b1;
    @(negedge clk);
    line_stb = 1'b0;
  endtask

  task automatic pix(bit exp, string req);
    pix_stb = 1'b1;
    @(negedge clk);
    pix_stb = 1'b0;
    chk(req, pix_act_o, exp);
    @(negedge clk);
    chk("R6 no strobe", pix_act_o, 0);
  endtask

  task automatic scan(bit keep, int first, int last, int n);
    new_field(keep);
    for (int l = 1; l <= n; l++) begin
      line();
      pix(keep && l >= first && l <= last, "R5 window");
    end
  endtask

  task automatic t_reset();
    chk("R1 reset act", pix_act_o, 0);
    chk("R1 reset start", fld_start_o, 0);
    chk("R1 reset odd", fld_odd_o, 0);
    line();
    pix(0, "R1 before first field");
    scan(1, 1, 1023, 6);
  endtask

  task automatic t_line0();
    wr(0, 16'd0);
    new_field(1);
    pix(0, "R4 line 0");
    line();
    pix(1, "R4 line 1");
    wr(0, 16'd1);
  endtask

  task automatic t_window();
    new_field(1);
    line();
    wr(0, 16'd3);
    wr(1, 16'd5);
    line();
    pix(1, "R7 old window held");
    scan(1, 3, 5, 7);
  endtask

  task automatic t_inverted();
    wr(0, 16'd6);
    wr(1, 16'd4);
    new_field(1);
    for (int l = 1; l <= 8; l++) begin
      line();
      pix(0, "R5 empty window");
    end
    wr(0, 16'd3);
    wr(1, 16'd5);
    scan(1, 3, 5, 6);
  endtask

  task automatic t_addr3();
    wr(3, 16'h0001);
    scan(1, 3, 5, 6);
    chk("R10 addr3 ignored", fld_odd_o, raw);
  endtask

  task automatic t_decim();
    wr(2, 16'd2);
    for (int f = 0; f < 7; f++) scan((f % 3) == 0, 3, 5, 4);
  endtask

  task automatic t_restart();
    wr(2, 16'd1);
    scan(1, 3, 5, 4);
    scan(0, 3, 5, 4);
    scan(1, 3, 5, 4);
    wr(2, 16'd1);
    scan(1, 3, 5, 4);
    scan(0, 3, 5, 4);
    chk("R9 restart done", 1, 1);
  endtask

  task automatic t_pol();
    wr(2, 16'h0100);
    pol = 1'b1;
    new_field(1);
    new_field(1);
    wr(2, 16'h0000);
    pol = 1'b0;
    new_field(1);
    new_field(1);
  endtask

  task automatic t_max();
    wr(2, 16'd31);
    for (int f = 0; f < 33; f++) new_field((f % 32) == 0);
    chk("R8 one of 32", 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_line0();
    t_window();
    t_inverted();
    t_addr3();
    t_decim();
    t_restart();
    t_pol();
    t_max();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule